// File: doc/BRIEF.md
# Ring-Buffer Remote DMA Port

This block is the host-side data window into a local packet buffer. The host first loads a start page, a stop page, a current byte address and a remaining byte count through a small register-load port. Each later access to the data port moves 1, 2 or 4 bytes between the port and the buffer at the current address. The access then moves the address forward, folds it back into the ring, and lowers the remaining count.

When the count reaches zero, a completion bit is latched in an interrupt status vector. The interrupt output follows that status through a mask. Writes that arrive after the count is exhausted are dropped. Reads keep working, and each one still moves the pointer. The buffer is built from four byte-wide synchronous lanes, so an access of any width may start at any byte address. Read data comes back one cycle after the request.

Top module: `rdma_port`

## Requirements
- R1: Every performed data-port access adds its byte size (1, 2 or 4) to the 16-bit current address, modulo 2^16.
- R2: If the advanced address equals exactly stop_page*256, it is replaced by start_page*256. An address that steps over that boundary without landing on it is kept unchanged.
- R3: If the remaining count is less than or equal to the access size, the count becomes zero and status bit DONE_BIT (default 6) is set. Otherwise the size is subtracted from the count.
- R4: A normal access (port_wide=0) moves 2 bytes when configuration bit 0 is 1 and 1 byte when it is 0. A wide access (port_wide=1) always moves 4 bytes.
- R5: A port write while the remaining count is zero writes no buffer byte and leaves the address, count and status unchanged.
- R6: A port read is always performed, including when the count is zero. One cycle later port_rvalid is 1 and port_rdata holds the bytes at the access address. Byte i sits in bits [8i+7:8i], and bytes beyond the access size read as zero.
- R7: A performed write stores port_wdata byte i at buffer byte (address+i) modulo the buffer size, little-endian.
- R8: irq is 1 exactly when some status bit is 1 and its mask bit is 1. Loading the status register clears each bit written as 1. A completion in the same cycle as such a clear leaves the bit set.
- R9: Register loads use reg_sel encodings 0 start page, 1 stop page, 2 address, 3 count, 4 configuration (bit 0), 5 mask, 6 status clear. Pages take reg_wdata[7:0]. After reset, address, count, status, mask and configuration are all zero.
- R10: When port_rd and port_wr are both 1 in the same cycle, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register load strobe |
| reg_sel | input | 3 | Register select (see R9) |
| reg_wdata | input | 16 | Register load value |
| port_rd | input | 1 | Data-port read request |
| port_wr | input | 1 | Data-port write request |
| port_wide | input | 1 | 4-byte access when 1 |
| port_wdata | input | 32 | Write data, little-endian |
| port_rdata | output | 32 | Read data, valid when port_rvalid |
| port_rvalid | output | 1 | Read data valid, one cycle after port_rd |
| cur_addr | output | 16 | Current byte address |
| cur_count | output | 16 | Remaining byte count |
| int_status | output | ST_W | Interrupt status vector |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench targets these corner cases:
- A word access landing exactly on the stop boundary, and a wide access jumping over it. A design using a greater-or-equal test would wrap the second one.
- A count smaller than the access size. A plain subtractor would wrap the count to a large value and never raise completion.
- Writes with an exhausted count, which a careless design would still store or count.
- Wide accesses at odd addresses, where a lane-rotation error shows up as swapped bytes.
- Reads with a zero count, which must still advance the pointer and re-assert completion.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;
   typedef enum logic [2:0] {
      SEL_START  = 3'd0,
      SEL_STOP   = 3'd1,
      SEL_ADDR   = 3'd2,
      SEL_COUNT  = 3'd3,
      SEL_CFG    = 3'd4,
      SEL_MASK   = 3'd5,
      SEL_STATUS = 3'd6,
      SEL_NONE   = 3'd7
   } rdma_sel_e;
endpackage

// File: rtl/rdma_lane_ram.sv
`timescale 1ns/1ps
// One byte-wide lane of the packet buffer, synchronous single port.
module rdma_lane_ram #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) cells[addr] <= wdata;
         else    rdata       <= cells[addr];
      end
   end
endmodule

// File: rtl/rdma_buf.sv
`timescale 1ns/1ps
// Four byte lanes; an access of nbytes starting at any byte address.
module rdma_buf #(
   parameter int BUF_AW = 10
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [BUF_AW-1:0] base,
   input  logic [2:0]        nbytes,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);
   localparam int LANES   = 4;
   localparam int LANE_AW = BUF_AW - 2;

   logic [7:0] lane_dout [LANES];
   logic [1:0] base_lo_q;
   logic [2:0] nbytes_q;

   always_ff @(posedge clk) begin
      if (en && !we) begin
         base_lo_q <= base[1:0];
         nbytes_q  <= nbytes;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [1:0]        off;
      logic              hit;
      logic [BUF_AW-1:0] baddr;
      logic [1:0]        src;

      assign off   = 2'(l) - base[1:0];
      assign hit   = ({1'b0, off} < nbytes);
      assign baddr = base + BUF_AW'(off);

      rdma_lane_ram #(.AW(LANE_AW)) u_ram (
         .clk   (clk),
         .en    (en && hit),
         .we    (we),
         .addr  (baddr[BUF_AW-1:2]),
         .wdata (wdata[{off, 3'b000} +: 8]),
         .rdata (lane_dout[l])
      );

      // Output byte l comes from the lane holding address base+l.
      assign src = base_lo_q + 2'(l);
      assign rdata[l*8 +: 8] = (3'(l) < nbytes_q) ? lane_dout[src] : 8'h00;
   end
endmodule

// File: rtl/rdma_ptr.sv
`timescale 1ns/1ps
// Current address and remaining count with ring fold and clamp.
module rdma_ptr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [2:0]        nbytes,
   input  logic              ld_addr,
   input  logic              ld_cnt,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic [ADDR_W-9:0] start_pg,
   input  logic [ADDR_W-9:0] stop_pg,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] cnt_q,
   output logic              done
);
   logic [ADDR_W-1:0] size_w, adv, nxt_addr, nxt_cnt;
   logic              exhaust;

   always_comb begin
      size_w   = ADDR_W'(nbytes);
      adv      = addr_q + size_w;
      nxt_addr = (adv == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : adv;
      exhaust  = (cnt_q <= size_w);
      nxt_cnt  = exhaust ? '0 : cnt_q - size_w;
      done     = step && exhaust;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (ld_addr)   addr_q <= ld_val;
         else if (step) addr_q <= nxt_addr;
         if (ld_cnt)    cnt_q  <= ld_val;
         else if (step) cnt_q  <= nxt_cnt;
      end
   end

   // R3: count moves down by the size or clamps to zero
   assert_cnt_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_cnt) |=>
         ((cnt_q == '0) || (cnt_q == $past(cnt_q) - ADDR_W'($past(nbytes)))));

   // R2: landing on the stop boundary folds back to the start page
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_addr && ((addr_q + ADDR_W'(nbytes)) == {stop_pg, 8'h00})) |=>
         (addr_q == {$past(start_pg), 8'h00}));

   // R1: away from the boundary the address moves by the size
   assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_addr && ((addr_q + ADDR_W'(nbytes)) != {stop_pg, 8'h00})) |=>
         (addr_q == $past(addr_q) + ADDR_W'($past(nbytes))));
endmodule

// File: rtl/rdma_irq.sv
`timescale 1ns/1ps
// Interrupt status (write-one-to-clear), mask and masked request.
module rdma_irq #(
   parameter int ST_W     = 8,
   parameter int DONE_BIT = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_done,
   input  logic            clr_we,
   input  logic            mask_we,
   input  logic [ST_W-1:0] wdata,
   output logic [ST_W-1:0] status_q,
   output logic            irq
);
   logic [ST_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= wdata;
   end

   for (genvar b = 0; b < ST_W; b++) begin : g_bit
      if (b == DONE_BIT) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n)                   status_q[b] <= 1'b0;
            else if (set_done)            status_q[b] <= 1'b1;
            else if (clr_we && wdata[b])  status_q[b] <= 1'b0;
         end
         // R8: completion outranks a simultaneous clear
         assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_done |=> status_q[b]);
      end else begin : g_nosrc
         always_ff @(posedge clk) begin
            if (!rst_n)                   status_q[b] <= 1'b0;
            else if (clr_we && wdata[b])  status_q[b] <= 1'b0;
         end
      end
      // R8: a written one clears the bit when nothing sets it
      assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wdata[b] && !(set_done && (b == DONE_BIT))) |=> !status_q[b]);
   end

   assign irq = |(status_q & mask_q);
endmodule

// File: rtl/rdma_port.sv
`timescale 1ns/1ps
module rdma_port #(
   parameter int ADDR_W   = 16,
   parameter int BUF_AW   = 10,
   parameter int ST_W     = 8,
   parameter int DONE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [15:0]       reg_wdata,
   input  logic              port_rd,
   input  logic              port_wr,
   input  logic              port_wide,
   input  logic [31:0]       port_wdata,
   output logic [31:0]       port_rdata,
   output logic              port_rvalid,
   output logic [15:0]       cur_addr,
   output logic [15:0]       cur_count,
   output logic [ST_W-1:0]   int_status,
   output logic              irq
);
   import rdma_pkg::*;

   localparam int PG_W = ADDR_W - 8;

   if (ADDR_W != 16) begin : g_bad_addr
      $error("rdma_port: ADDR_W must be 16");
   end
   if (BUF_AW < 3 || BUF_AW > ADDR_W) begin : g_bad_buf
      $error("rdma_port: BUF_AW out of range");
   end
   if (DONE_BIT < 0 || DONE_BIT >= ST_W || ST_W > 16) begin : g_bad_st
      $error("rdma_port: status geometry invalid");
   end

   rdma_sel_e       sel;
   logic [PG_W-1:0] start_pg, stop_pg;
   logic            dcfg_q;
   logic            acc_rd, acc_wr, step, done;
   logic [2:0]      nbytes;

   assign sel    = rdma_sel_e'(reg_sel);
   assign acc_rd = port_rd;
   assign acc_wr = port_wr && !port_rd && (cur_count != '0);
   assign step   = acc_rd || acc_wr;
   assign nbytes = port_wide ? 3'd4 : (dcfg_q ? 3'd2 : 3'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_pg    <= '0;
         stop_pg     <= '0;
         dcfg_q      <= 1'b0;
         port_rvalid <= 1'b0;
      end else begin
         port_rvalid <= acc_rd;
         if (reg_wr && sel == SEL_START) start_pg <= reg_wdata[PG_W-1:0];
         if (reg_wr && sel == SEL_STOP)  stop_pg  <= reg_wdata[PG_W-1:0];
         if (reg_wr && sel == SEL_CFG)   dcfg_q   <= reg_wdata[0];
      end
   end

   rdma_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .nbytes   (nbytes),
      .ld_addr  (reg_wr && sel == SEL_ADDR),
      .ld_cnt   (reg_wr && sel == SEL_COUNT),
      .ld_val   (reg_wdata),
      .start_pg (start_pg),
      .stop_pg  (stop_pg),
      .addr_q   (cur_addr),
      .cnt_q    (cur_count),
      .done     (done)
   );

   rdma_buf #(.BUF_AW(BUF_AW)) u_buf (
      .clk    (clk),
      .en     (step),
      .we     (acc_wr),
      .base   (cur_addr[BUF_AW-1:0]),
      .nbytes (nbytes),
      .wdata  (port_wdata),
      .rdata  (port_rdata)
   );

   rdma_irq #(.ST_W(ST_W), .DONE_BIT(DONE_BIT)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_done (done),
      .clr_we   (reg_wr && sel == SEL_STATUS),
      .mask_we  (reg_wr && sel == SEL_MASK),
      .wdata    (reg_wdata[ST_W-1:0]),
      .status_q (int_status),
      .irq      (irq)
   );

   // R5: a write with an exhausted count leaves the pointer untouched
   assert_blocked_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && !port_rd && !reg_wr && cur_count == '0) |=>
         (cur_addr == $past(cur_addr) && cur_count == '0));

   // R6: every read request yields valid data on the next cycle
   assert_rvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      port_rd |=> port_rvalid);

   // R3: an access that drains the count latches completion
   assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cur_count <= 16'(nbytes)) |=> int_status[DONE_BIT]);
endmodule

// File: tb/test_rdma_port.sv
`timescale 1ns/1ps
module test_rdma_port;
   localparam int BUF_B = 1024;
   localparam int DB    = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic        port_rd = 1'b0, port_wr = 1'b0, port_wide = 1'b0;
   logic [31:0] port_wdata = '0;
   logic [31:0] port_rdata;
   logic        port_rvalid;
   logic [15:0] cur_addr, cur_count;
   logic [7:0]  int_status;
   logic        irq;

   always #2.5 clk = ~clk;

   rdma_port i_rdma_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .port_rd(port_rd), .port_wr(port_wr),
      .port_wide(port_wide), .port_wdata(port_wdata), .port_rdata(port_rdata),
      .port_rvalid(port_rvalid), .cur_addr(cur_addr), .cur_count(cur_count),
      .int_status(int_status), .irq(irq)
   );

   // Behavioural reference state
   byte unsigned m_mem [BUF_B];
   int unsigned  m_addr = 0, m_cnt = 0, m_start = 0, m_stop = 0;
   int unsigned  m_cfg = 0, m_mask = 0, m_stat = 0;
   bit           m_rv = 0;
   logic [31:0]  m_rd = '0;
   int checks = 0, failures = 0;

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk({tag, " R1 R2"}, "addr", cur_addr, m_addr);
      chk({tag, " R3"}, "count", cur_count, m_cnt);
      chk({tag, " R3 R8"}, "status", int_status, m_stat);
      chk({tag, " R8"}, "irq", irq, ((m_stat & m_mask) != 0));
      chk({tag, " R6"}, "rvalid", port_rvalid, m_rv);
      if (m_rv) chk({tag, " R6 R7"}, "rdata", port_rdata, m_rd);
   endtask

   function automatic void m_advance(input int unsigned n);
      m_addr = (m_addr + n) & 32'hFFFF;
      if (m_addr == (m_stop << 8)) m_addr = m_start << 8;
      if (m_cnt <= n) begin
         m_cnt = 0;
         m_stat |= (1 << DB);
      end else m_cnt -= n;
   endfunction

   task automatic regw(input int sel, input int unsigned val, input string tag);
      reg_wr = 1'b1; reg_sel = 3'(sel); reg_wdata = 16'(val);
      @(posedge clk); #1;
      m_rv = 0;
      case (sel)
         0: m_start = val & 8'hFF;
         1: m_stop  = val & 8'hFF;
         2: m_addr  = val & 16'hFFFF;
         3: m_cnt   = val & 16'hFFFF;
         4: m_cfg   = val & 1;
         5: m_mask  = val & 8'hFF;
         6: m_stat  = m_stat & ~(val & 8'hFF);
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 1'b0;
      compare(tag);
   endtask

   task automatic op(input bit rd, input bit wr, input bit wide,
                     input logic [31:0] wd, input string tag);
      int unsigned n;
      port_rd = rd; port_wr = wr; port_wide = wide; port_wdata = wd;
      @(posedge clk); #1;
      n = wide ? 4 : (m_cfg ? 2 : 1);
      m_rv = rd;
      if (rd) begin
         m_rd = '0;
         for (int i = 0; i < int'(n); i++) m_rd[i*8 +: 8] = m_mem[(m_addr + i) % BUF_B];
         m_advance(n);
      end else if (wr && m_cnt != 0) begin
         for (int i = 0; i < int'(n); i++) m_mem[(m_addr + i) % BUF_B] = wd[i*8 +: 8];
         m_advance(n);
      end
      @(negedge clk);
      port_rd = 0; port_wr = 0; port_wide = 0;
      compare(tag);
   endtask

   initial begin
      #500000;
      failures++;
      $display("FAIL R1 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R9 reset");

      // R7 R9: fill the whole buffer with wide writes
      regw(1, 8'hFF, "R9"); regw(0, 0, "R9"); regw(2, 0, "R9"); regw(3, BUF_B, "R9");
      for (int k = 0; k < BUF_B / 4; k++) op(0, 1, 1, 32'(k) * 32'h9E3779B1, "R7 fill");

      // R8: mask then clear the completion bit
      regw(5, 8'h40, "R8 mask");
      regw(6, 8'h40, "R8 clear");

      // R5: writes dropped with count zero, then read shows old data (R6)
      op(0, 1, 1, 32'hDEADBEEF, "R5");
      op(0, 1, 0, 32'h000000AA, "R5");
      op(1, 0, 1, 0, "R5 R6 zero-count read");

      // R4: byte then word accesses
      regw(2, 16'h0013, "R4"); regw(3, 5, "R4"); regw(4, 0, "R4");
      for (int k = 0; k < 3; k++) op(1, 0, 0, 0, "R4 byte");
      regw(4, 1, "R4");
      op(1, 0, 0, 0, "R4 word R3");

      // R7: odd-address wide write and read-back
      regw(2, 16'h0021, "R7"); regw(3, 8, "R7");
      op(0, 1, 1, 32'h11223344, "R7 odd");
      regw(2, 16'h0021, "R7");
      op(1, 0, 1, 0, "R6 R7 odd readback");

      // R2: exact landing folds, overshoot does not
      regw(0, 8'h01, "R2"); regw(1, 8'h02, "R2");
      regw(2, 16'h01FE, "R2"); regw(3, 16'h40, "R2");
      op(1, 0, 0, 0, "R2 exact");
      regw(2, 16'h01FE, "R2");
      op(1, 0, 1, 0, "R2 overshoot");
      regw(4, 0, "R2"); regw(2, 16'h01FF, "R2");
      op(1, 0, 0, 0, "R2 byte");

      // R10: read and write together
      regw(3, 16'h10, "R10");
      op(1, 1, 1, 32'hCAFEF00D, "R10");

      // R3: count below the access size clamps
      regw(6, 8'hFF, "R3"); regw(3, 3, "R3");
      op(0, 1, 1, 32'h55AA55AA, "R3 clamp");

      // Mixed traffic across the ring
      regw(0, 0, "mix"); regw(1, 3, "mix"); regw(2, 16'h02F0, "mix");
      for (int k = 0; k < 400; k++) begin
         int unsigned r = $urandom;
         if (r % 23 == 0) regw(3, (r >> 8) % 40, "R3 mix");
         else if (r % 29 == 0) regw(4, (r >> 9) & 1, "R4 mix");
         else if (r % 31 == 0) regw(6, 8'h40, "R8 mix");
         else op(r[3], r[4], r[5], $urandom, "mix");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule